// File: doc/BRIEF.md
# Interrupt Pin Swizzle Router

This block turns interrupt assert and deassert requests from several device lanes into single-cycle raise or lower commands for a numbered system interrupt line. Each lane presents its 8-bit device/function identifier and the content of its interrupt-pin byte (the byte at configuration offset 0x3D, where 1 means the first pin and 4 the fourth). The router rotates the pin by the slot number to choose one of four shared interrupt links. It then looks up the line number for that link in one of four routing bytes.

The routing bytes are written and read through a byte-wide configuration port at offsets 0x60 to 0x63, one byte per link in link order. A byte with bit 7 set marks its link as unrouted. Requests are captured into a per-lane pending slot, and a pending request is served one per cycle. When several are pending, the lowest device number goes first.

Top module: `irqsw_router`

## Requirements
- R1: While reset is asserted and after its release, the four routing bytes read 0x80 and cmd_valid is 0.
- R2: A configuration write to offset 0x60+k (k = 0..3) stores the whole data byte in routing byte k, and cfg_rdata returns it whenever cfg_addr selects that offset. Writes to any other offset change no routing byte, and reads of any other offset return 0.
- R3: The device number is devfn bits 7:3. The link is ((pin - 1) + (device - 1)) mod 4, and cmd_irq is bits 3:0 of the routing byte of that link.
- R4: cmd_raise is 1 for an assert request (req_raise = 1) and 0 for a deassert request; both directions use the same link computation.
- R5: A lone request accepted at clock edge k produces cmd_valid high for exactly the one cycle after edge k+1.
- R6: A request whose pin value is 0 or greater than 4 is dropped and never produces a command.
- R7: If bit 7 of the selected routing byte is set when the request is served, the request is consumed and no command is issued.
- R8: Simultaneously pending requests are served one per cycle in ascending device number, with equal device numbers going to the lower lane index.
- R9: A new valid request on a lane whose earlier request is still pending replaces it, so only the latest direction is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_DEV | Per-lane request strobe |
| req_raise | input | N_DEV | Per-lane direction: 1 assert, 0 deassert |
| req_devfn | input | N_DEV*8 | Per-lane device/function identifier, lane 0 in the low byte |
| req_pin | input | N_DEV*8 | Per-lane interrupt-pin byte, lane 0 in the low byte |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Routing byte at cfg_addr, or 0 |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_raise | output | 1 | 1 raise, 0 lower |
| cmd_irq | output | 4 | Selected interrupt line number |

## Verification
The hardest case to reach from the ports is a lane that is still pending and receives a second request in the same cycle that another lane is served. The replacement must win over the clear, and the queue order must still hold. Directed sequences force this by pairing a low-numbered device with a high-numbered one and then re-requesting the high one on the next cycle. Seeded random traffic with all four lanes busy, out-of-range pins and writes around the routing window covers the rest. It is compared cycle by cycle against a bench model of the pending slots and the routing bytes.

// File: rtl/irqsw_pkg.sv
package irqsw_pkg;

   localparam int LINK_CNT = 4;
   localparam int LINK_W   = 2;

   typedef struct packed {
      logic              raise;
      logic [LINK_W-1:0] link;
   } irqsw_slot_t;

   // rotate the pin by the slot: ((pin-1)+(dev-1)) mod 4
   function automatic logic [LINK_W-1:0] swz_link(input logic [LINK_W-1:0] pin_lo,
                                                  input logic [LINK_W-1:0] dev_lo);
      return pin_lo + dev_lo - LINK_W'(2);
   endfunction

endpackage

// File: rtl/irqsw_route_bank.sv
module irqsw_route_bank #(
   parameter int          N_LINK    = 4,
   parameter int          CFG_AW    = 8,
   parameter int          BYTE_W    = 8,
   parameter logic [7:0]  ROUTE_BASE = 8'h60,
   parameter logic [7:0]  ROUTE_RST  = 8'h80
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_wr,
   input  logic [CFG_AW-1:0]          cfg_addr,
   input  logic [BYTE_W-1:0]          cfg_wdata,
   output logic [BYTE_W-1:0]          cfg_rdata,
   output logic [N_LINK*BYTE_W-1:0]   route_flat
);

   logic [N_LINK-1:0] hit;

   generate
      for (genvar k = 0; k < N_LINK; k++) begin : g_byte
         logic [BYTE_W-1:0] q;
         assign hit[k] = (cfg_addr == CFG_AW'(ROUTE_BASE) + CFG_AW'(k));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= BYTE_W'(ROUTE_RST);
            else if (cfg_wr && hit[k])
               q <= cfg_wdata;
         end
         assign route_flat[k*BYTE_W +: BYTE_W] = q;
      end
   endgenerate

   always_comb begin
      cfg_rdata = '0;
      for (int k = 0; k < N_LINK; k++)
         if (hit[k])
            cfg_rdata = route_flat[k*BYTE_W +: BYTE_W];
   end

endmodule

// File: rtl/irqsw_lane.sv
module irqsw_lane
   import irqsw_pkg::*;
#(
   parameter int DEVFN_W = 8,
   parameter int PIN_W   = 8,
   parameter int MAX_PIN = 4,
   localparam int DEV_W  = DEVFN_W - 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic               in_raise,
   input  logic [DEVFN_W-1:0] in_devfn,
   input  logic [PIN_W-1:0]   in_pin,
   input  logic               grant,
   output logic               pend,
   output irqsw_slot_t        slot,
   output logic [DEV_W-1:0]   dev_q
);

   logic             pin_ok;
   logic             accept;
   logic [DEV_W-1:0] dev_in;
   logic             unused_fn;

   assign dev_in    = in_devfn[DEVFN_W-1:3];
   assign unused_fn = ^in_devfn[2:0];
   assign pin_ok    = (in_pin != '0) && (in_pin <= PIN_W'(MAX_PIN));
   assign accept    = in_valid && pin_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend  <= 1'b0;
         slot  <= '0;
         dev_q <= '0;
      end else if (accept) begin
         pend       <= 1'b1;
         slot.raise <= in_raise;
         slot.link  <= swz_link(in_pin[LINK_W-1:0], dev_in[LINK_W-1:0]);
         dev_q      <= dev_in;
      end else if (grant) begin
         pend <= 1'b0;
      end
   end

endmodule

// File: rtl/irqsw_pick.sv
module irqsw_pick #(
   parameter int N_DEV  = 4,
   parameter int DEV_W  = 5,
   parameter int ORDER  = 0,
   localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
   input  logic [N_DEV-1:0]       pend,
   input  logic [N_DEV*DEV_W-1:0] dev_flat,
   output logic                   gnt_valid,
   output logic [IDX_W-1:0]       gnt_idx,
   output logic [N_DEV-1:0]       gnt_onehot
);

   assign gnt_valid = |pend;

   generate
      if (ORDER == 0) begin : g_by_dev
         always_comb begin
            logic             found;
            logic [DEV_W-1:0] best;
            found   = 1'b0;
            best    = '0;
            gnt_idx = '0;
            for (int i = 0; i < N_DEV; i++) begin
               if (pend[i] && (!found || dev_flat[i*DEV_W +: DEV_W] < best)) begin
                  found   = 1'b1;
                  best    = dev_flat[i*DEV_W +: DEV_W];
                  gnt_idx = IDX_W'(i);
               end
            end
         end
      end else begin : g_by_lane
         logic unused_dev;
         assign unused_dev = ^dev_flat;
         always_comb begin
            gnt_idx = '0;
            for (int i = N_DEV - 1; i >= 0; i--)
               if (pend[i])
                  gnt_idx = IDX_W'(i);
         end
      end
   endgenerate

   always_comb begin
      gnt_onehot = '0;
      if (gnt_valid)
         gnt_onehot[gnt_idx] = 1'b1;
   end

endmodule

// File: rtl/irqsw_router.sv
module irqsw_router
   import irqsw_pkg::*;
#(
   parameter int         N_DEV      = 4,
   parameter int         DEVFN_W    = 8,
   parameter int         PIN_W      = 8,
   parameter int         IRQ_W      = 4,
   parameter int         CFG_AW     = 8,
   parameter int         MAX_PIN    = 4,
   parameter int         ORDER      = 0,
   parameter logic [7:0] ROUTE_BASE = 8'h60,
   parameter logic [7:0] ROUTE_RST  = 8'h80
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_DEV-1:0]          req_valid,
   input  logic [N_DEV-1:0]          req_raise,
   input  logic [N_DEV*DEVFN_W-1:0]  req_devfn,
   input  logic [N_DEV*PIN_W-1:0]    req_pin,
   input  logic                      cfg_wr,
   input  logic [CFG_AW-1:0]         cfg_addr,
   input  logic [7:0]                cfg_wdata,
   output logic [7:0]                cfg_rdata,
   output logic                      cmd_valid,
   output logic                      cmd_raise,
   output logic [IRQ_W-1:0]          cmd_irq
);

   localparam int BYTE_W = 8;
   localparam int N_LINK = LINK_CNT;
   localparam int DEV_W  = DEVFN_W - 3;
   localparam int IDX_W  = (N_DEV > 1) ? $clog2(N_DEV) : 1;

   generate
      if (N_DEV < 1)             begin : g_bad_ndev  $error("N_DEV must be at least 1"); end
      if (DEVFN_W < 5)           begin : g_bad_devfn $error("DEVFN_W too narrow"); end
      if (IRQ_W > BYTE_W - 1)    begin : g_bad_irq   $error("IRQ_W must leave bit 7 free"); end
      if (MAX_PIN != N_LINK)     begin : g_bad_pin   $error("MAX_PIN must equal link count"); end
      if (PIN_W < LINK_W)        begin : g_bad_pinw  $error("PIN_W too narrow"); end
      if (ORDER != 0 && ORDER != 1) begin : g_bad_ord $error("ORDER must be 0 or 1"); end
   endgenerate

   logic [N_LINK*BYTE_W-1:0] route_flat;
   logic [N_DEV-1:0]         pend_vec;
   logic [N_DEV-1:0]         gnt_onehot;
   logic [N_DEV*DEV_W-1:0]   dev_flat;
   irqsw_slot_t              slots [N_DEV];
   logic                     arb_valid;
   logic [IDX_W-1:0]         gnt_idx;
   irqsw_slot_t              arb_slot;
   logic [BYTE_W-1:0]        arb_byte;
   logic                     unused_byte;

   irqsw_route_bank #(
      .N_LINK     (N_LINK),
      .CFG_AW     (CFG_AW),
      .BYTE_W     (BYTE_W),
      .ROUTE_BASE (ROUTE_BASE),
      .ROUTE_RST  (ROUTE_RST)
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .route_flat (route_flat)
   );

   generate
      for (genvar i = 0; i < N_DEV; i++) begin : g_lane
         irqsw_lane #(
            .DEVFN_W (DEVFN_W),
            .PIN_W   (PIN_W),
            .MAX_PIN (MAX_PIN)
         ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (req_valid[i]),
            .in_raise (req_raise[i]),
            .in_devfn (req_devfn[i*DEVFN_W +: DEVFN_W]),
            .in_pin   (req_pin[i*PIN_W +: PIN_W]),
            .grant    (gnt_onehot[i]),
            .pend     (pend_vec[i]),
            .slot     (slots[i]),
            .dev_q    (dev_flat[i*DEV_W +: DEV_W])
         );
      end
   endgenerate

   irqsw_pick #(
      .N_DEV (N_DEV),
      .DEV_W (DEV_W),
      .ORDER (ORDER)
   ) u_pick (
      .pend       (pend_vec),
      .dev_flat   (dev_flat),
      .gnt_valid  (arb_valid),
      .gnt_idx    (gnt_idx),
      .gnt_onehot (gnt_onehot)
   );

   assign arb_slot    = slots[gnt_idx];
   assign arb_byte    = route_flat[arb_slot.link*BYTE_W +: BYTE_W];
   assign unused_byte = ^arb_byte[BYTE_W-2:IRQ_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_raise <= 1'b0;
         cmd_irq   <= '0;
      end else begin
         cmd_valid <= arb_valid && !arb_byte[BYTE_W-1];
         cmd_raise <= arb_slot.raise;
         cmd_irq   <= arb_byte[IRQ_W-1:0];
      end
   end

endmodule

// File: rtl/irqsw_router_chk.sv
module irqsw_router_chk #(
   parameter int         N_DEV      = 4,
   parameter int         PIN_W      = 8,
   parameter int         CFG_AW     = 8,
   parameter int         MAX_PIN    = 4,
   parameter logic [7:0] ROUTE_BASE = 8'h60,
   parameter logic [7:0] ROUTE_RST  = 8'h80
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cfg_wr,
   input logic [CFG_AW-1:0]      cfg_addr,
   input logic [7:0]             cfg_wdata,
   input logic [N_DEV-1:0]       req_valid,
   input logic [N_DEV*PIN_W-1:0] req_pin,
   input logic [N_DEV-1:0]       pend_vec,
   input logic                   arb_valid,
   input logic [7:0]             arb_byte,
   input logic [31:0]            route_flat,
   input logic                   cmd_valid
);

   logic in_win;
   assign in_win = (cfg_addr >= CFG_AW'(ROUTE_BASE)) && (cfg_addr < CFG_AW'(ROUTE_BASE) + CFG_AW'(4));

   p_reset_bytes_r1: assert property (@(posedge clk)
      !rst_n |=> (route_flat == {4{ROUTE_RST}}) && !cmd_valid);

   for (genvar k = 0; k < 4; k++) begin : g_wr
      p_win_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_wr && cfg_addr == CFG_AW'(ROUTE_BASE) + CFG_AW'(k)
         |=> route_flat[k*8 +: 8] == $past(cfg_wdata));
   end

   p_out_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_wr || !in_win) |=> $stable(route_flat));

   p_cmd_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(arb_valid));

   for (genvar i = 0; i < N_DEV; i++) begin : g_pin
      p_bad_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid[i] && !pend_vec[i] &&
         (req_pin[i*PIN_W +: PIN_W] == '0 || req_pin[i*PIN_W +: PIN_W] > PIN_W'(MAX_PIN))
         |=> !pend_vec[i]);
   end

   p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      arb_valid && arb_byte[7] |=> !cmd_valid);

   p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(|req_valid) && (|pend_vec) |=> $countones(pend_vec) + 1 == $past($countones(pend_vec)));

endmodule

bind irqsw_router irqsw_router_chk #(
   .N_DEV      (N_DEV),
   .PIN_W      (PIN_W),
   .CFG_AW     (CFG_AW),
   .MAX_PIN    (MAX_PIN),
   .ROUTE_BASE (ROUTE_BASE),
   .ROUTE_RST  (ROUTE_RST)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_wr     (cfg_wr),
   .cfg_addr   (cfg_addr),
   .cfg_wdata  (cfg_wdata),
   .req_valid  (req_valid),
   .req_pin    (req_pin),
   .pend_vec   (pend_vec),
   .arb_valid  (arb_valid),
   .arb_byte   (arb_byte),
   .route_flat (route_flat),
   .cmd_valid  (cmd_valid)
);

// File: tb/irqsw_router_bench.sv
module irqsw_router_bench;

   localparam int N = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   req_valid = '0;
   logic [N-1:0]   req_raise = '0;
   logic [N*8-1:0] req_devfn = '0;
   logic [N*8-1:0] req_pin = '0;
   logic           cfg_wr = 1'b0;
   logic [7:0]     cfg_addr = '0;
   logic [7:0]     cfg_wdata = '0;
   logic [7:0]     cfg_rdata;
   logic           cmd_valid;
   logic           cmd_raise;
   logic [3:0]     cmd_irq;

   int  checks = 0;
   int  fails = 0;
   bit  done = 0;

   // bench model
   bit       m_pend [N];
   bit       m_raise [N];
   int       m_dev [N];
   int       m_pin [N];
   bit [7:0] m_route [4];

   always #5 clk = ~clk;

   irqsw_router u_irqsw_router (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_raise (req_raise),
      .req_devfn (req_devfn), .req_pin (req_pin),
      .cfg_wr (cfg_wr), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .cmd_valid (cmd_valid), .cmd_raise (cmd_raise), .cmd_irq (cmd_irq)
   );

   function automatic int link_of(int pin, int dev);
      return (pin - 1 + dev - 1) & 3;
   endfunction

   function automatic bit pin_ok(int pin);
      return pin >= 1 && pin <= 4;
   endfunction

   task automatic check(string tag, int got, int exp, string what);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
      end
   endtask

   task automatic drive(int lane, bit raise, int devfn, int pin);
      req_valid[lane] = 1'b1;
      req_raise[lane] = raise;
      req_devfn[lane*8 +: 8] = 8'(devfn);
      req_pin[lane*8 +: 8] = 8'(pin);
   endtask

   task automatic cfg(int addr, int data);
      cfg_wr = 1'b1;
      cfg_addr = 8'(addr);
      cfg_wdata = 8'(data);
   endtask

   // one clock with model prediction and output compare
   task automatic tick(string tag);
      int  best;
      int  lk;
      bit  ev;
      bit  er;
      int  ei;
      best = -1;
      for (int i = 0; i < N; i++)
         if (m_pend[i] && (best < 0 || m_dev[i] < m_dev[best]))
            best = i;
      ev = 0; er = 0; ei = 0;
      if (best >= 0) begin
         lk = link_of(m_pin[best], m_dev[best]);
         ev = !m_route[lk][7];
         er = m_raise[best];
         ei = int'(m_route[lk][3:0]);
         m_pend[best] = 0;
      end
      for (int i = 0; i < N; i++)
         if (req_valid[i] && pin_ok(int'(req_pin[i*8 +: 8]))) begin
            m_pend[i]  = 1;
            m_raise[i] = req_raise[i];
            m_dev[i]   = int'(req_devfn[i*8+3 +: 5]);
            m_pin[i]   = int'(req_pin[i*8 +: 8]);
         end
      if (cfg_wr && cfg_addr >= 8'h60 && cfg_addr <= 8'h63)
         m_route[cfg_addr - 8'h60] = cfg_wdata;
      @(posedge clk);
      #1;
      req_valid = '0;
      cfg_wr = 1'b0;
      checks++;
      if (cmd_valid !== ev || (ev && (cmd_raise !== er || cmd_irq !== 4'(ei)))) begin
         fails++;
         $display("FAIL %s cmd: actual v=%0b r=%0b irq=%0h expected v=%0b r=%0b irq=%0h",
                  tag, cmd_valid, cmd_raise, cmd_irq, ev, er, ei);
      end
   endtask

   task automatic rd_check(int addr, int exp, string tag);
      cfg_addr = 8'(addr);
      #1;
      check(tag, int'(cfg_rdata), exp, "cfg_rdata");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_raise[i] = 0; m_dev[i] = 0; m_pin[i] = 0; end
      for (int k = 0; k < 4; k++) m_route[k] = 8'h80;

      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check("R1", int'(cmd_valid), 0, "cmd_valid in reset");
      for (int k = 0; k < 4; k++) rd_check(8'h60 + k, 8'h80, "R1");
      @(negedge clk);
      rst_n = 1'b1;
      tick("R1");
      for (int k = 0; k < 4; k++) rd_check(8'h60 + k, 8'h80, "R1");

      // R2: routing window writes and readback
      cfg(8'h60, 8'h05); tick("R2");
      cfg(8'h61, 8'h09); tick("R2");
      cfg(8'h62, 8'h0A); tick("R2");
      cfg(8'h63, 8'h0B); tick("R2");
      rd_check(8'h60, 8'h05, "R2"); rd_check(8'h61, 8'h09, "R2");
      rd_check(8'h62, 8'h0A, "R2"); rd_check(8'h63, 8'h0B, "R2");
      cfg(8'h64, 8'h33); tick("R2");
      cfg(8'h5F, 8'h44); tick("R2");
      rd_check(8'h64, 0, "R2"); rd_check(8'h5F, 0, "R2");
      rd_check(8'h60, 8'h05, "R2"); rd_check(8'h63, 8'h0B, "R2");

      // R5: latency of a lone request (dev 1, pin 1 -> link 0 -> line 5)
      drive(0, 1'b1, 8'h08, 1);
      tick("R5");
      check("R5", int'(cmd_valid), 0, "no command one edge after accept");
      tick("R5");
      check("R5", int'(cmd_valid), 1, "command after second edge");
      check("R3", int'(cmd_irq), 5, "dev1 pin1 line");
      tick("R5");
      check("R5", int'(cmd_valid), 0, "command lasts one cycle");

      // R3: swizzle by slot and pin
      drive(1, 1'b1, 8'h10, 1); tick("R3"); tick("R3");   // dev2 pin1 -> link1 -> 9
      drive(2, 1'b1, 8'h0F, 4); tick("R3"); tick("R3");   // dev1 pin4 -> link3 -> B
      drive(3, 1'b1, 8'h02, 1); tick("R3"); tick("R3");   // dev0 pin1 -> link3 -> B
      drive(0, 1'b1, 8'h1B, 2); tick("R3"); tick("R3");   // dev3 pin2 -> link3
      drive(0, 1'b1, 8'h18, 3); tick("R3"); tick("R3");   // dev3 pin3 -> link0 -> 5

      // R4: deassert uses the same link
      drive(1, 1'b0, 8'h10, 1); tick("R4"); tick("R4");
      check("R4", int'(cmd_raise), 0, "lower flag");
      check("R4", int'(cmd_irq), 9, "lower line");

      // R6: pin 0 and pin 5 ignored
      drive(0, 1'b1, 8'h08, 0); drive(1, 1'b1, 8'h08, 5);
      tick("R6"); tick("R6"); tick("R6");
      check("R6", int'(cmd_valid), 0, "no command for bad pin");

      // R7: unrouted link consumes the request silently
      cfg(8'h61, 8'h85); tick("R7");
      drive(2, 1'b1, 8'h10, 1); tick("R7"); tick("R7");
      check("R7", int'(cmd_valid), 0, "disabled link");
      tick("R7");
      cfg(8'h61, 8'h09); tick("R7");

      // R8: simultaneous requests, ascending device with lane tie-break
      drive(0, 1'b1, 8'h38, 1); drive(1, 1'b0, 8'h18, 2);
      drive(2, 1'b1, 8'h28, 3); drive(3, 1'b1, 8'h19, 4);
      for (int c = 0; c < 6; c++) tick("R8");

      // R9: re-request replaces a still-pending one
      drive(1, 1'b1, 8'h08, 1); drive(0, 1'b1, 8'h48, 1);
      tick("R9");
      drive(0, 1'b0, 8'h48, 1);
      tick("R9");
      tick("R9");
      check("R9", int'(cmd_raise), 0, "latest direction wins");
      tick("R9"); tick("R9");

      // R8: seeded random traffic
      for (int c = 0; c < 400; c++) begin
         for (int i = 0; i < N; i++)
            if ($urandom_range(2) == 0)
               drive(i, 1'($urandom_range(1)), int'($urandom_range(255)), int'($urandom_range(5)));
         if ($urandom_range(7) == 0)
            cfg(8'h5E + int'($urandom_range(7)),
                ($urandom_range(3) == 0) ? int'($urandom_range(255)) : int'($urandom_range(127)));
         tick("R8");
      end
      for (int c = 0; c < 8; c++) tick("R8");
      for (int k = 0; k < 4; k++) rd_check(8'h60 + k, int'(m_route[k]), "R2");

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule